// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Four-Word Lines

This block is a read/write data cache for a 32-bit physical byte address. It is direct mapped. Each line holds four 32-bit words, a stored tag and a valid flag. A request splits its address into four fields: tag, line index, word select and byte offset. A lookup hits only when the indexed line is valid and its stored tag equals the request tag. The word select then picks one word of the line through a four-way word multiplexer.

Writes are write-through. The word is updated in the line, and the full address and the data go into a small write buffer. That buffer drains in order to a simple memory write port, so a write does not wait for memory. A miss refills the whole line with a four-beat burst from the memory read port. The refill does not start until the write buffer is empty, so it never reads a word that is still waiting in the buffer. A write miss first refills the line and then updates only the addressed word.

After reset a sequential sweep clears every valid flag, one line per cycle. New requests are refused until the sweep ends.

The request side is valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. The requester holds the request fields steady until that edge. `req_ready` is high only while the cache is idle, so one request is in flight at a time. Each accepted request, read or write, gets exactly one single-cycle `rsp_valid` pulse. The response channel has no back-pressure.

On the memory side:
- **Burst request channel:** `mem_rd_valid` stays high with a stable address until `mem_rd_ready` is seen.
- **Read data channel:** one word moves on each edge where `mem_rdata_valid` and `mem_rdata_ready` are both high.
- **Write channel:** `mem_wr_valid` stays high with stable address and data until `mem_wr_ready` is seen.

Top module: `dmc_cache`

## Requirements
- R1: Address fields, for the default 4096 lines:
  - bits [15:4] are the line index.
  - bits [31:16] are the tag. In general it is every bit above the index.
  - bits [3:2] select the word within the line.
  - bits [1:0] are a byte offset that does not affect which word is read or written.
- R2: The response reports `rsp_hit`=1 only if the indexed line was valid with an equal tag when the request was looked up. A line holding a different tag, or an invalid line, gives `rsp_hit`=0.
- R3: A read hit returns the word chosen by the word select on `rsp_rdata`. `rsp_valid` rises on the edge right after the edge that accepted the request.
- R4: On a miss, the cache issues one burst request whose address is the line base (low four bits zero). It takes four beats into word positions 0, 1, 2 and 3 in that order. It marks the line valid with the new tag only after the last beat. It then answers with `rsp_hit`=0, and a read returns the refilled word.
- R5: A write puts its data into the addressed word of the cache and acknowledges with one `rsp_valid` pulse. A write miss refills the line first, so the other three words of the line hold memory contents afterwards.
- R6: Each write pushes its full address and data into a write buffer of depth 4. The buffer drains to the memory write port in arrival order. A write that finds the buffer full is not acknowledged until an entry has drained.
- R7: A miss does not raise `mem_rd_valid` while the write buffer holds any entry. A later refill of a written line therefore returns the written data.
- R8: Reset clears all valid flags through a sweep of one line per cycle. `req_ready` stays low for exactly as many cycles as there are lines after reset is released. After the sweep every earlier resident line misses.
- R9: `req_ready` is low from the accepting edge until the edge that raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse per accepted request |
| rsp_hit | output | 1 | Request hit on its first lookup |
| rsp_rdata | output | WORD_W | Read word (meaningful for reads) |
| mem_rd_valid | output | 1 | Burst read request |
| mem_rd_ready | input | 1 | Memory accepts the burst request |
| mem_rd_addr | output | ADDR_W | Line-aligned burst address |
| mem_rdata_valid | input | 1 | Burst beat present |
| mem_rdata_ready | output | 1 | Cache accepts a beat |
| mem_rdata | input | WORD_W | Burst beat data |
| mem_wr_valid | output | 1 | Write buffer holds an entry |
| mem_wr_ready | input | 1 | Memory accepts the head entry |
| mem_wr_addr | output | ADDR_W | Address of the head entry |
| mem_wr_data | output | WORD_W | Data of the head entry |

## Verification
A read or write hit answers one edge after its accepting edge. The bench drives and samples on falling edges, so this shows up as `rsp_valid` on the second falling edge after the handshake, and the bench checks that exact count. Miss responses wait on an open-ended refill, so the bench waits for `rsp_valid` to appear and then checks `rsp_hit`, the data and the order of the burst beats. The buffer-full stall and the refill-waits-for-drain rule are checked by holding `mem_wr_ready` low for twenty cycles, confirming that no response or burst request appears, and then releasing it. The reset sweep is counted in falling edges from reset release to the first high `req_ready`.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_LOOK,
    ST_DRAIN,
    ST_FILL
  } ctl_state_e;

  typedef enum logic [1:0] {
    FL_IDLE,
    FL_REQ,
    FL_BEAT,
    FL_DONE
  } fill_state_e;
endpackage

// File: rtl/dmc_store.sv
module dmc_store #(
  parameter int INDEX_W = 12,
  parameter int TAG_W   = 16,
  parameter int WORD_W  = 32,
  parameter int OFF_W   = 2
) (
  input  logic                     clk,
  input  logic                     clr_en,
  input  logic [INDEX_W-1:0]       clr_idx,
  input  logic [INDEX_W-1:0]       rd_idx,
  input  logic [TAG_W-1:0]         rd_tag,
  input  logic [OFF_W-1:0]         rd_off,
  output logic                     hit,
  output logic [WORD_W-1:0]        rd_word,
  input  logic                     line_we,
  input  logic [TAG_W-1:0]         line_tag,
  input  logic [(WORD_W<<OFF_W)-1:0] line_data,
  input  logic                     word_we,
  input  logic [WORD_W-1:0]        word_data
);
  localparam int LINES      = 1 << INDEX_W;
  localparam int LINE_WORDS = 1 << OFF_W;

  logic [LINES-1:0]   valid_q;
  logic [TAG_W-1:0]   tag_q [LINES];
  logic [WORD_W-1:0]  lane_rd [LINE_WORDS];

  // valid flags and tags: the sweep clear has priority over a refill
  always_ff @(posedge clk) begin
    if (clr_en) begin
      valid_q[clr_idx] <= 1'b0;
    end else if (line_we) begin
      valid_q[rd_idx] <= 1'b1;
      tag_q[rd_idx]   <= line_tag;
    end
  end

  // one storage lane per word position of the line
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] lane_q [LINES];
    always_ff @(posedge clk) begin
      if (line_we) begin
        lane_q[rd_idx] <= line_data[w*WORD_W +: WORD_W];
      end else if (word_we && (rd_off == OFF_W'(w))) begin
        lane_q[rd_idx] <= word_data;
      end
    end
    assign lane_rd[w] = lane_q[rd_idx];
  end

  assign hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_word = lane_rd[rd_off];
endmodule

// File: rtl/dmc_wbuf.sv
module dmc_wbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [WORD_W-1:0] push_data,
  output logic              full,
  output logic              empty,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [WORD_W-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [WORD_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;
  assign out_addr  = addr_q[rd_ptr];
  assign out_data  = data_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/dmc_fill.sv
module dmc_fill
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          line_addr,
  output logic                       mem_rd_valid,
  input  logic                       mem_rd_ready,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  input  logic                       mem_rdata_valid,
  output logic                       mem_rdata_ready,
  input  logic [WORD_W-1:0]          mem_rdata,
  output logic                       done,
  output logic [(WORD_W<<OFF_W)-1:0] line_data
);
  localparam int LINE_WORDS = 1 << OFF_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  fill_state_e       st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  beat_q;
  logic [WORD_W-1:0] beat_buf [LINE_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FL_IDLE;
      addr_q <= '0;
      beat_q <= '0;
    end else begin
      case (st_q)
        FL_IDLE: if (start) begin
          addr_q <= line_addr;
          st_q   <= FL_REQ;
        end
        FL_REQ: if (mem_rd_ready) begin
          beat_q <= '0;
          st_q   <= FL_BEAT;
        end
        FL_BEAT: if (mem_rdata_valid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_q <= FL_DONE;
        end
        default: st_q <= FL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == FL_BEAT && mem_rdata_valid) beat_buf[beat_q] <= mem_rdata;
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_pack
    assign line_data[w*WORD_W +: WORD_W] = beat_buf[w];
  end

  assign mem_rd_valid    = (st_q == FL_REQ);
  assign mem_rd_addr     = addr_q;
  assign mem_rdata_ready = (st_q == FL_BEAT);
  assign done            = (st_q == FL_DONE);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int INDEX_W  = 12,
  parameter int OFF_W    = 2,
  parameter int WORD_W   = 32,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rdata_valid,
  output logic              mem_rdata_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int LOW_W  = OFF_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - LOW_W;
  localparam int LINES  = 1 << INDEX_W;
  localparam int LINE_W = WORD_W << OFF_W;
  localparam logic [INDEX_W-1:0] LAST_LINE = INDEX_W'(LINES - 1);

  ctl_state_e        st_q;
  logic [INDEX_W-1:0] clr_q;
  logic              rq_write;
  logic [ADDR_W-1:0] rq_addr;
  logic [WORD_W-1:0] rq_wdata;
  logic              missed_q;
  logic              rsp_valid_q, rsp_hit_q;
  logic [WORD_W-1:0] rsp_rdata_q;

  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   tag;
  logic [OFF_W-1:0]   off;
  logic               hit;
  logic [WORD_W-1:0]  rd_word;
  logic               respond, word_we, fill_start, fill_done, line_we;
  logic               wb_full, wb_empty;
  logic [LINE_W-1:0]  fill_line;
  logic [ADDR_W-1:0]  line_base;

  assign idx       = rq_addr[LOW_W +: INDEX_W];
  assign off       = rq_addr[BYTE_W +: OFF_W];
  assign tag       = rq_addr[ADDR_W-1 -: TAG_W];
  assign line_base = {rq_addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};

  assign req_ready  = (st_q == ST_IDLE);
  assign respond    = (st_q == ST_LOOK) && hit && (!rq_write || !wb_full);
  assign word_we    = respond && rq_write;
  assign fill_start = (st_q == ST_DRAIN) && wb_empty;
  assign line_we    = (st_q == ST_FILL) && fill_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_CLEAR;
      clr_q       <= '0;
      rq_write    <= 1'b0;
      rq_addr     <= '0;
      rq_wdata    <= '0;
      missed_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      case (st_q)
        ST_CLEAR: begin
          clr_q <= clr_q + 1'b1;
          if (clr_q == LAST_LINE) st_q <= ST_IDLE;
        end
        ST_IDLE: if (req_valid) begin
          rq_write <= req_write;
          rq_addr  <= req_addr;
          rq_wdata <= req_wdata;
          missed_q <= 1'b0;
          st_q     <= ST_LOOK;
        end
        ST_LOOK: begin
          if (respond)  st_q <= ST_IDLE;
          else if (!hit) st_q <= ST_DRAIN;
        end
        ST_DRAIN: if (wb_empty) st_q <= ST_FILL;
        ST_FILL: if (fill_done) begin
          missed_q <= 1'b1;
          st_q     <= ST_LOOK;
        end
        default: st_q <= ST_IDLE;
      endcase
      rsp_valid_q <= respond;
      if (respond) begin
        rsp_hit_q   <= !missed_q;
        rsp_rdata_q <= rd_word;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_rdata = rsp_rdata_q;

  dmc_store #(
    .INDEX_W(INDEX_W), .TAG_W(TAG_W), .WORD_W(WORD_W), .OFF_W(OFF_W)
  ) i_store (
    .clk      (clk),
    .clr_en   (st_q == ST_CLEAR),
    .clr_idx  (clr_q),
    .rd_idx   (idx),
    .rd_tag   (tag),
    .rd_off   (off),
    .hit      (hit),
    .rd_word  (rd_word),
    .line_we  (line_we),
    .line_tag (tag),
    .line_data(fill_line),
    .word_we  (word_we),
    .word_data(rq_wdata)
  );

  dmc_wbuf #(
    .DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) i_wbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (word_we),
    .push_addr(rq_addr),
    .push_data(rq_wdata),
    .full     (wb_full),
    .empty    (wb_empty),
    .out_valid(mem_wr_valid),
    .out_ready(mem_wr_ready),
    .out_addr (mem_wr_addr),
    .out_data (mem_wr_data)
  );

  dmc_fill #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W)
  ) i_fill (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (fill_start),
    .line_addr      (line_base),
    .mem_rd_valid   (mem_rd_valid),
    .mem_rd_ready   (mem_rd_ready),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rdata_valid(mem_rdata_valid),
    .mem_rdata_ready(mem_rdata_ready),
    .mem_rdata      (mem_rdata),
    .done           (fill_done),
    .line_data      (fill_line)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 12,
  parameter int LOW_W   = 4,
  parameter int WORD_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [WORD_W-1:0] mem_wr_data
);
  localparam int LINES = 1 << INDEX_W;

  logic [INDEX_W:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != (INDEX_W+1)'(LINES)) since_rst <= since_rst + 1'b1;
  end

  // R8
  clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < (INDEX_W+1)'(LINES)) |-> !req_ready);

  // R8
  clear_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == (INDEX_W+1)'(LINES)) && ($past(since_rst) != since_rst) |-> req_ready);

  // R4
  burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[LOW_W-1:0] == '0));

  // R4
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R7
  fill_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !mem_wr_valid);

  // R9
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> !$past(req_ready));
endmodule

bind dmc_cache dmc_checker #(
  .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .LOW_W(LOW_W), .WORD_W(WORD_W)
) i_dmc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data)
);

// File: tb/test_dmc_cache.sv
`timescale 1ns/1ps
module test_dmc_cache;
  localparam int IDX_W = 4;
  localparam int NLINES = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_hit;
  logic [31:0] rsp_rdata;
  logic        mem_rd_valid, mem_rd_ready, mem_rdata_valid, mem_rdata_ready;
  logic [31:0] mem_rd_addr, mem_rdata;
  logic        mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_wr_addr, mem_wr_data;

  always #2.5 clk = ~clk;

  dmc_cache #(.ADDR_W(32), .INDEX_W(IDX_W), .OFF_W(2), .WORD_W(32), .WB_DEPTH(4)) i_dmc_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rdata_valid(mem_rdata_valid), .mem_rdata_ready(mem_rdata_ready), .mem_rdata(mem_rdata),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int n_bursts = 0;
  bit wr_en = 1'b1;

  // bench-side models
  logic [31:0] memw   [int unsigned];
  logic [31:0] shadow [int unsigned];
  logic [31:0] exp_wq [$];
  bit          mv [NLINES];
  logic [23:0] mt [NLINES];

  function automatic logic [31:0] init_val(input logic [31:0] wa);
    return (wa * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  function automatic logic [31:0] mem_get(input logic [31:0] wa);
    return memw.exists(wa) ? memw[wa] : init_val(wa);
  endfunction

  function automatic logic [31:0] want(input logic [31:0] wa);
    return shadow.exists(wa) ? shadow[wa] : init_val(wa);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: drives on falling edges, transfers happen at the next rising edge
  initial begin : mem_model
    bit busy = 1'b0;
    bit rr_prev = 1'b0;
    int beat = 0;
    int dly = 0;
    logic [31:0] base = '0;
    mem_rd_ready = 1'b0; mem_rdata_valid = 1'b0; mem_rdata = '0; mem_wr_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        busy = 1'b0; rr_prev = 1'b0;
        mem_rd_ready = 1'b0; mem_rdata_valid = 1'b0; mem_wr_ready = 1'b0;
      end else begin
        if (mem_rdata_valid && rr_prev) begin
          beat++;
          if (beat == 4) busy = 1'b0;
        end
        if (busy && dly > 0) dly--;
        mem_rdata_valid = busy && (dly == 0);
        mem_rdata = mem_get((base >> 2) + 32'(beat));
        mem_rd_ready = !busy;
        if (mem_rd_valid && mem_rd_ready) begin
          busy = 1'b1; base = mem_rd_addr; beat = 0; dly = 2; n_bursts++;
          // R4 burst address is the line base
          chk(mem_rd_addr[3:0] == 4'h0, "R4", "burst address alignment", mem_rd_addr, {mem_rd_addr[31:4], 4'h0});
        end
        rr_prev = mem_rdata_ready;
        mem_wr_ready = wr_en;
        if (mem_wr_valid && mem_wr_ready) begin
          memw[mem_wr_addr >> 2] = mem_wr_data;
          // R6 drain in arrival order, full address and data
          if (exp_wq.size() >= 2) begin
            chk(mem_wr_addr == exp_wq[0] && mem_wr_data == exp_wq[1], "R6",
                "write drain order", mem_wr_addr, exp_wq[0]);
            void'(exp_wq.pop_front()); void'(exp_wq.pop_front());
          end else begin
            chk(1'b0, "R6", "unexpected memory write", mem_wr_addr, 32'h0);
          end
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output bit hit, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    rd = rsp_rdata; hit = rsp_hit;
  endtask

  // full check of one access against the bench model
  task automatic run(input bit wr, input logic [31:0] a, input logic [31:0] d, input string req);
    logic [31:0] rd;
    bit hit;
    int lat;
    int li = int'(a[7:4]);
    bit exp_hit = mv[li] && (mt[li] == a[31:8]);
    if (wr) begin exp_wq.push_back(a); exp_wq.push_back(d); end
    access(wr, a, d, rd, hit, lat);
    chk(hit == exp_hit, exp_hit ? "R2" : "R2/R4", "hit flag", 32'(hit), 32'(exp_hit));
    if (!wr) chk(rd == want(a >> 2), req, "read data", rd, want(a >> 2));
    if (exp_hit) chk(lat == 2, "R3", "hit response cycle", 32'(lat), 32'd2);
    mv[li] = 1'b1; mt[li] = a[31:8];
    if (wr) shadow[a >> 2] = d;
  endtask

  task automatic do_reset();
    int cnt = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!rsp_valid && !mem_rd_valid && !mem_wr_valid && !req_ready, "R8", "outputs in reset",
        {28'h0, rsp_valid, mem_rd_valid, mem_wr_valid, req_ready}, 32'h0);
    rst_n = 1'b1;
    while (!req_ready && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt == NLINES, "R8", "clear sweep length", 32'(cnt), 32'(NLINES));
    foreach (mv[i]) mv[i] = 1'b0;
  endtask

  task automatic drain();
    while (mem_wr_valid) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    bit hit;
    int lat;
    int bursts0;
    bit got;
    bit saw_rd;
    do_reset();

    // R1 R3 R4: sweep every line and word, varying the byte offset
    for (int l = 0; l < NLINES; l++)
      for (int w = 0; w < 4; w++)
        run(1'b0, {24'h000A00, 4'(l), 2'(w), 2'(w)}, 32'h0, w == 0 ? "R4" : "R1");

    // R2: conflicting tag in every line, then original tag again
    for (int l = 0; l < NLINES; l++) begin
      run(1'b0, {24'h00B301, 4'(l), 2'(l % 4), 2'b00}, 32'h0, "R2");
      run(1'b0, {24'h000A00, 4'(l), 2'((l + 1) % 4), 2'b00}, 32'h0, "R2");
    end

    // R5: write hits on every word, read back
    for (int l = 0; l < NLINES; l++) begin
      for (int w = 0; w < 4; w++)
        run(1'b1, {24'h000A00, 4'(l), 2'(w), 2'b00}, 32'hC0DE0000 + 32'(l * 16 + w), "R5");
      drain();
      for (int w = 0; w < 4; w++)
        run(1'b0, {24'h000A00, 4'(l), 2'(w), 2'b11}, 32'h0, "R5");
    end

    // R5: write miss refills, then only the addressed word changes
    bursts0 = n_bursts;
    run(1'b1, {24'h00C700, 4'd5, 2'd2, 2'b00}, 32'hFEEDF00D, "R5");
    chk(n_bursts == bursts0 + 1, "R5", "write miss refill count", 32'(n_bursts), 32'(bursts0 + 1));
    for (int w = 0; w < 4; w++)
      run(1'b0, {24'h00C700, 4'd5, 2'(w), 2'b00}, 32'h0, "R5");
    drain();

    // R6: buffer of four fills without stalling, the fifth write waits
    wr_en = 1'b0;
    for (int w = 0; w < 4; w++)
      run(1'b1, {24'h000A00, 4'd3, 2'(w), 2'b00}, 32'h51000000 + 32'(w), "R6");
    exp_wq.push_back({24'h000A00, 4'd3, 2'd1, 2'b00});
    exp_wq.push_back(32'h5100AAAA);
    got = 1'b0;
    fork
      begin
        access(1'b1, {24'h000A00, 4'd3, 2'd1, 2'b00}, 32'h5100AAAA, rd, hit, lat);
        got = 1'b1;
      end
      begin
        repeat (20) @(negedge clk);
        chk(!got && !rsp_valid, "R6", "no ack while buffer full", 32'(got), 32'h0);
        chk(mem_wr_valid == 1'b1, "R6", "buffer pending", 32'(mem_wr_valid), 32'h1);
        wr_en = 1'b1;
      end
    join
    chk(got && hit, "R6", "ack after drain", 32'(hit), 32'h1);
    shadow[{24'h000A00, 4'd3, 2'd1} ] = 32'h5100AAAA;
    drain();
    run(1'b0, {24'h000A00, 4'd3, 2'd1, 2'b00}, 32'h0, "R6");

    // R7: a miss waits for the buffer to drain, refill sees written data
    wr_en = 1'b0;
    run(1'b1, {24'h000A00, 4'd9, 2'd0, 2'b00}, 32'h77770009, "R7");
    saw_rd = 1'b0;
    fork
      run(1'b0, {24'h00D100, 4'd9, 2'd0, 2'b00}, 32'h0, "R7");
      begin
        repeat (20) begin @(negedge clk); if (mem_rd_valid) saw_rd = 1'b1; end
        chk(!saw_rd, "R7", "no burst while buffer holds data", 32'(saw_rd), 32'h0);
        wr_en = 1'b1;
      end
    join
    run(1'b0, {24'h000A00, 4'd9, 2'd0, 2'b00}, 32'h0, "R7");
    drain();

    // R8: a reset mid-run invalidates every line
    do_reset();
    for (int l = 0; l < NLINES; l++)
      run(1'b0, {24'h000A00, 4'(l), 2'd3, 2'b00}, 32'h0, "R8");

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule